// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a synchronous system clock domain and an external 256K x 8 asynchronous static RAM. It accepts one single-byte read or write at a time over a request/acknowledge port and turns it into the select, output-enable and write-enable waveforms the RAM needs. It also produces the enable for the shared data pins. The RAM has an active-low select and an active-high select. The controller moves both together, so the chip is selected only while the controller owns a cycle, and is otherwise deselected at its lowest current.

Every phase length is a parameter in clock cycles. Each is computed at elaboration from a nanosecond timing figure and the clock period, as the ceiling of the quotient with a floor of one cycle. Moving to a slower speed grade or a different clock therefore means editing the nanosecond parameters only. A retention request parks the RAM deselected until a wake input arrives. After the wake, the controller waits one full read-cycle time before it accepts the next access.

Top module: `sram_async_ctl`

The controller is a state machine with eight states:

- IDLE: the chip is deselected. A retention request moves to RETAIN, a write moves to WR_SETUP, and a read moves to RD_SETUP.
- Read path: RD_SETUP moves to RD_WAIT, RD_WAIT moves to RD_DONE, and RD_DONE returns to IDLE.
- Write path: WR_SETUP moves to WR_PULSE, WR_PULSE moves to WR_RECOVER, and WR_RECOVER returns to IDLE.
- RETAIN: after a wake, RETAIN returns to IDLE once its recovery count has expired.

Each timed state leaves when its phase counter reaches its last cycle.

## Requirements
- R1: While reset is low, and in the cycle after it, both selects are inactive (mem_sel_n_lo high, mem_sel_hi low). In that cycle mem_rd_en_n and mem_wr_en_n are high, and mem_dq_oe, req_ack and rsp_valid are low.
- R2: A request (req_valid high) is taken only in IDLE, and only when retain_req is low. req_ack is a single-cycle pulse visible right after the accepting clock edge. A request held high through an operation is acknowledged again only after the controller has come back to IDLE.
- R3: A read selects the chip with mem_rd_en_n high for one cycle (RD_SETUP). mem_rd_en_n then goes low for RD_WAIT cycles, which is the largest of (access count minus 1), output-enable count and (read-cycle count minus 1). mem_wr_en_n stays high throughout, and mem_rd_en_n falls one cycle after req_ack appears.
- R4: Read data is sampled from mem_dq_in on the last RD_WAIT cycle. It appears on rsp_rdata with rsp_valid high for exactly one cycle, RD_WAIT+1 cycles after req_ack appears.
- R5: A write first holds the chip selected with both enables high for WR_SETUP cycles, where WR_SETUP equals the output-turn-off count. It then drives mem_wr_en_n low for WR_PULSE cycles, the largest of the pulse-width count, the data-setup count, and the select-to-end and address-to-end counts each minus WR_SETUP. It then keeps the chip selected with mem_wr_en_n high for WR_RECOVER cycles, which is the larger of 1 and (write-cycle count minus WR_SETUP minus WR_PULSE). mem_wr_en_n is never low while mem_rd_en_n is low or while the chip is deselected.
- R6: mem_dq_oe rises together with the fall of mem_wr_en_n and falls one cycle after mem_wr_en_n rises. While mem_dq_oe is high, mem_dq_out holds the accepted write byte unchanged.
- R7: mem_dq_oe rises only after at least the output-turn-off count of cycles has passed since the RAM was last asked to drive its outputs, so the RAM and the controller never drive the data pins at the same time.
- R8: Address and write data are registered at acceptance. mem_addr stays constant while the chip is selected, regardless of later changes on req_addr and req_wdata.
- R9: retain_req seen in IDLE enters RETAIN and takes precedence over a simultaneous req_valid. In RETAIN the chip stays deselected and no request is acknowledged.
- R10: wake_req sampled in RETAIN starts a recovery of read-cycle-count cycles. A request held pending is acknowledged exactly read-cycle-count+1 cycles after the wake edge, and the chip stays deselected until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Byte address |
| req_wdata | input | 8 | Write byte |
| req_ack | output | 1 | One-cycle acceptance pulse |
| rsp_rdata | output | 8 | Captured read byte |
| rsp_valid | output | 1 | One-cycle read-data strobe |
| retain_req | input | 1 | Enter low-power retention (taken in IDLE) |
| wake_req | input | 1 | Leave retention |
| mem_addr | output | 18 | RAM address pins |
| mem_sel_n_lo | output | 1 | Active-low chip select |
| mem_sel_hi | output | 1 | Active-high chip select |
| mem_rd_en_n | output | 1 | Active-low output enable |
| mem_wr_en_n | output | 1 | Active-low write enable |
| mem_dq_out | output | 8 | Byte driven toward the data pins |
| mem_dq_oe | output | 1 | Controller drives the data pins when high |
| mem_dq_in | input | 8 | Byte read back from the data pins |

## Verification
Results are due at fixed distances from the acknowledge. Under the default parameters these are:

- For a read, output enable falls 1 cycle after req_ack and rsp_valid arrives 18 cycles after it.
- For a write, write enable falls 7 cycles after req_ack, rises 14 cycles later, and the chip deselects 1 cycle after that.
- A held request after a read is acknowledged again 20 cycles after the first acknowledge.
- After a wake, the pending request is acknowledged 19 cycles after the wake edge.

The bench drives inputs and samples outputs on falling edges. It stamps every output transition with the number of rising edges seen so far, and compares differences of those stamps against counts it derives itself from the nanosecond figures. A cycle-level RAM model returns corrupted data when it is sampled too early. The same model records any too-short write pulse, too-short data setup or bus overlap.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_SETUP,
        ST_RD_WAIT,
        ST_RD_DONE,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_RECOVER,
        ST_RETAIN
    } ctl_state_e;

    // Convert a nanosecond figure to whole clock cycles, never fewer than one.
    function automatic int ns_to_cycles(input int ns, input int period_ns);
        int c;
        c = (ns + period_ns - 1) / period_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
// Down-counter that marks the final cycle of a timed phase.
module sram_phase_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign last = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/sram_data_path.sv
// Write-byte holding register and read-byte capture register.
module sram_data_path #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_wdata,
    input  logic [DATA_W-1:0] wdata_in,
    input  logic              capture,
    input  logic [DATA_W-1:0] pin_in,
    output logic [DATA_W-1:0] pin_out,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] wbyte_q;
    logic [DATA_W-1:0] rbyte_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wbyte_q <= '0;
        end else if (load_wdata) begin
            wbyte_q <= wdata_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rbyte_q <= '0;
        end else if (capture) begin
            rbyte_q <= pin_in;
        end
    end

    assign pin_out = wbyte_q;
    assign rdata   = rbyte_q;

endmodule

// File: rtl/sram_async_ctl.sv
module sram_async_ctl
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W        = 18,
    parameter int DATA_W        = 8,
    parameter int CLK_PERIOD_NS = 4,
    parameter int T_RC_NS       = 70,
    parameter int T_AA_NS       = 70,
    parameter int T_OE_NS       = 35,
    parameter int T_WC_NS       = 70,
    parameter int T_CW_NS       = 65,
    parameter int T_AW_NS       = 65,
    parameter int T_WP_NS       = 55,
    parameter int T_DW_NS       = 30,
    parameter int T_OHZ_NS      = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ack,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_valid,
    input  logic              retain_req,
    input  logic              wake_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_sel_n_lo,
    output logic              mem_sel_hi,
    output logic              mem_rd_en_n,
    output logic              mem_wr_en_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);

    // Raw interval counts from the nanosecond figures.
    localparam int N_RC  = ns_to_cycles(T_RC_NS,  CLK_PERIOD_NS);
    localparam int N_AA  = ns_to_cycles(T_AA_NS,  CLK_PERIOD_NS);
    localparam int N_OE  = ns_to_cycles(T_OE_NS,  CLK_PERIOD_NS);
    localparam int N_WC  = ns_to_cycles(T_WC_NS,  CLK_PERIOD_NS);
    localparam int N_CW  = ns_to_cycles(T_CW_NS,  CLK_PERIOD_NS);
    localparam int N_AW  = ns_to_cycles(T_AW_NS,  CLK_PERIOD_NS);
    localparam int N_WP  = ns_to_cycles(T_WP_NS,  CLK_PERIOD_NS);
    localparam int N_DW  = ns_to_cycles(T_DW_NS,  CLK_PERIOD_NS);
    localparam int N_OHZ = ns_to_cycles(T_OHZ_NS, CLK_PERIOD_NS);

    // Phase lengths.
    localparam int LEN_RD_WAIT  = imax(imax(N_AA - 1, N_OE), imax(N_RC - 1, 1));
    localparam int LEN_WR_SETUP = N_OHZ;
    localparam int LEN_WR_PULSE = imax(imax(N_WP, N_DW),
                                       imax(N_CW - LEN_WR_SETUP, N_AW - LEN_WR_SETUP));
    localparam int LEN_WR_REC   = imax(1, N_WC - LEN_WR_SETUP - LEN_WR_PULSE);
    localparam int LEN_WAKE     = N_RC;
    localparam int LEN_MAX      = imax(imax(LEN_RD_WAIT, LEN_WR_SETUP),
                                       imax(imax(LEN_WR_PULSE, LEN_WR_REC), LEN_WAKE));
    localparam int CNT_W        = $clog2(LEN_MAX + 1);

    ctl_state_e        state_q, state_d;
    logic              accept;
    logic              wake_start;
    logic              waking_q;
    logic              timer_load;
    logic [CNT_W-1:0]  timer_val;
    logic              phase_last;
    logic              ack_q;
    logic              drive_hold_q;
    logic [ADDR_W-1:0] addr_q;
    logic              selected;

    function automatic logic [CNT_W-1:0] phase_len(input ctl_state_e s);
        logic [CNT_W-1:0] v;
        unique case (s)
            ST_RD_SETUP:   v = CNT_W'(1);
            ST_RD_WAIT:    v = CNT_W'(LEN_RD_WAIT);
            ST_RD_DONE:    v = CNT_W'(1);
            ST_WR_SETUP:   v = CNT_W'(LEN_WR_SETUP);
            ST_WR_PULSE:   v = CNT_W'(LEN_WR_PULSE);
            ST_WR_RECOVER: v = CNT_W'(LEN_WR_REC);
            default:       v = '0;
        endcase
        return v;
    endfunction

    assign accept     = (state_q == ST_IDLE) && !retain_req && req_valid;
    assign wake_start = (state_q == ST_RETAIN) && !waking_q && wake_req;

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (retain_req)     state_d = ST_RETAIN;
                else if (req_valid) state_d = req_write ? ST_WR_SETUP : ST_RD_SETUP;
            end
            ST_RD_SETUP:   if (phase_last) state_d = ST_RD_WAIT;
            ST_RD_WAIT:    if (phase_last) state_d = ST_RD_DONE;
            ST_RD_DONE:    if (phase_last) state_d = ST_IDLE;
            ST_WR_SETUP:   if (phase_last) state_d = ST_WR_PULSE;
            ST_WR_PULSE:   if (phase_last) state_d = ST_WR_RECOVER;
            ST_WR_RECOVER: if (phase_last) state_d = ST_IDLE;
            ST_RETAIN:     if (waking_q && phase_last) state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    assign timer_load = (state_d != state_q) || wake_start;
    assign timer_val  = wake_start ? CNT_W'(LEN_WAKE) : phase_len(state_d);

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Sequencing registers: acknowledge, wake flag, drive hold, address.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_q        <= 1'b0;
            waking_q     <= 1'b0;
            drive_hold_q <= 1'b0;
            addr_q       <= '0;
        end else begin
            ack_q        <= accept;
            drive_hold_q <= (state_q == ST_WR_PULSE);
            if (wake_start)                waking_q <= 1'b1;
            else if (state_q != ST_RETAIN) waking_q <= 1'b0;
            if (accept) addr_q <= req_addr;
        end
    end

    sram_phase_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (timer_load),
        .load_val (timer_val),
        .last     (phase_last)
    );

    sram_data_path #(
        .DATA_W (DATA_W)
    ) u_data (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_wdata (accept && req_write),
        .wdata_in   (req_wdata),
        .capture    ((state_q == ST_RD_WAIT) && phase_last),
        .pin_in     (mem_dq_in),
        .pin_out    (mem_dq_out),
        .rdata      (rsp_rdata)
    );

    // Output decode from the state register.
    always_comb begin
        selected    = 1'b0;
        mem_rd_en_n = 1'b1;
        mem_wr_en_n = 1'b1;
        mem_dq_oe   = 1'b0;
        rsp_valid   = 1'b0;
        unique case (state_q)
            ST_RD_SETUP: selected = 1'b1;
            ST_RD_WAIT: begin
                selected    = 1'b1;
                mem_rd_en_n = 1'b0;
            end
            ST_RD_DONE: rsp_valid = 1'b1;
            ST_WR_SETUP: selected = 1'b1;
            ST_WR_PULSE: begin
                selected    = 1'b1;
                mem_wr_en_n = 1'b0;
                mem_dq_oe   = 1'b1;
            end
            ST_WR_RECOVER: begin
                selected  = 1'b1;
                mem_dq_oe = drive_hold_q;
            end
            default: selected = 1'b0;
        endcase
    end

    assign mem_sel_n_lo = !selected;
    assign mem_sel_hi   = selected;
    assign mem_addr     = addr_q;
    assign req_ack      = ack_q;

endmodule

// File: rtl/sram_async_ctl_chk.sv
module sram_async_ctl_chk
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ack,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_sel_n_lo,
    input logic              mem_sel_hi,
    input logic              mem_rd_en_n,
    input logic              mem_wr_en_n,
    input logic [DATA_W-1:0] mem_dq_out,
    input logic              mem_dq_oe,
    input ctl_state_e        state_q
);

    logic sel;
    assign sel = !mem_sel_n_lo && mem_sel_hi;

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (mem_sel_n_lo && !mem_sel_hi && mem_rd_en_n && mem_wr_en_n
                    && !mem_dq_oe && !req_ack && !rsp_valid));

    p_ack_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |=> !req_ack);

    p_ack_from_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_ack) |-> $past(state_q) == ST_IDLE);

    p_rsp_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_no_we_with_oe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_wr_en_n |-> (sel && mem_rd_en_n));

    p_drive_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (sel && mem_rd_en_n));

    p_drive_starts_with_we_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> !mem_wr_en_n);

    p_drive_data_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out));

    p_addr_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && $past(sel)) |-> $stable(mem_addr));

    p_retain_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RETAIN) |-> (mem_sel_n_lo && !mem_sel_hi && !req_ack));

endmodule

bind sram_async_ctl sram_async_ctl_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_ack      (req_ack),
    .rsp_valid    (rsp_valid),
    .mem_addr     (mem_addr),
    .mem_sel_n_lo (mem_sel_n_lo),
    .mem_sel_hi   (mem_sel_hi),
    .mem_rd_en_n  (mem_rd_en_n),
    .mem_wr_en_n  (mem_wr_en_n),
    .mem_dq_out   (mem_dq_out),
    .mem_dq_oe    (mem_dq_oe),
    .state_q      (state_q)
);

// File: tb/sram_async_ctl_bench.sv
module sram_async_ctl_bench;

    localparam int PER = 4;

    // Independently derived expectations (nanoseconds from the requirements).
    function automatic int cy(input int ns);
        int c;
        c = (ns + PER - 1) / PER;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int E_RC   = cy(70);
    localparam int E_AA   = cy(70);
    localparam int E_OE   = cy(35);
    localparam int E_OHZ  = cy(25);
    localparam int E_WPMN = cy(55);
    localparam int E_DWMN = cy(30);
    localparam int E_RDW  = mx(mx(E_AA - 1, E_OE), E_RC - 1);
    localparam int E_WS   = E_OHZ;
    localparam int E_WP   = mx(mx(E_WPMN, E_DWMN), mx(cy(65) - E_WS, cy(65) - E_WS));
    localparam int E_WR   = mx(1, cy(70) - E_WS - E_WP);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [17:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        retain_req = 1'b0;
    logic        wake_req = 1'b0;
    logic        req_ack, rsp_valid;
    logic [7:0]  rsp_rdata;
    logic [17:0] mem_addr;
    logic        mem_sel_n_lo, mem_sel_hi, mem_rd_en_n, mem_wr_en_n, mem_dq_oe;
    logic [7:0]  mem_dq_out, mem_dq_in;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    int viol     = 0;

    always #2 clk = ~clk;

    sram_async_ctl u_sram_async_ctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_write    (req_write),
        .req_addr     (req_addr),
        .req_wdata    (req_wdata),
        .req_ack      (req_ack),
        .rsp_rdata    (rsp_rdata),
        .rsp_valid    (rsp_valid),
        .retain_req   (retain_req),
        .wake_req     (wake_req),
        .mem_addr     (mem_addr),
        .mem_sel_n_lo (mem_sel_n_lo),
        .mem_sel_hi   (mem_sel_hi),
        .mem_rd_en_n  (mem_rd_en_n),
        .mem_wr_en_n  (mem_wr_en_n),
        .mem_dq_out   (mem_dq_out),
        .mem_dq_oe    (mem_dq_oe),
        .mem_dq_in    (mem_dq_in)
    );

    // ---------------- cycle-level RAM model ----------------
    logic [7:0]  mem_m [0:1023];
    logic        m_sel, m_drive, m_good;
    logic [18:0] a_key, a_key_q;
    int acnt = 0, ocnt = 0, hcnt = 255, wcnt = 0, dcnt = 0;
    logic [17:0] waddr_m;
    logic [7:0]  wd_last;

    assign m_sel   = !mem_sel_n_lo && mem_sel_hi;
    assign m_drive = m_sel && !mem_rd_en_n && mem_wr_en_n;
    assign a_key   = {m_sel, mem_addr};
    assign m_good  = (a_key == a_key_q) && (acnt + 1 >= E_AA) && (ocnt + 1 >= E_OE);
    assign mem_dq_in = !m_drive ? 8'h00 :
                       (m_good ? mem_m[mem_addr[9:0]] : (mem_m[mem_addr[9:0]] ^ 8'hA5));

    initial begin
        for (int i = 0; i < 1024; i++) mem_m[i] = 8'h00;
        a_key_q = '0;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (a_key != a_key_q) begin
            a_key_q <= a_key;
            acnt    <= 1;
        end else if (acnt < 1000) begin
            acnt <= acnt + 1;
        end
        if (m_drive) ocnt <= (ocnt < 1000) ? ocnt + 1 : ocnt;
        else         ocnt <= 0;
        if (mem_dq_oe && m_drive) viol <= viol + 1;
        if (mem_dq_oe && hcnt < E_OHZ) viol <= viol + 1;
        if (m_drive) hcnt <= 0;
        else if (hcnt < 255) hcnt <= hcnt + 1;
        if (m_sel && !mem_wr_en_n) begin
            if (wcnt == 0) waddr_m <= mem_addr;
            else if (mem_addr != waddr_m) viol <= viol + 1;
            wcnt <= wcnt + 1;
            if (mem_dq_oe && wcnt > 0 && mem_dq_out == wd_last) dcnt <= dcnt + 1;
            else dcnt <= mem_dq_oe ? 1 : 0;
            wd_last <= mem_dq_out;
        end else if (wcnt != 0) begin
            if (wcnt < E_WPMN || dcnt < E_DWMN) viol <= viol + 1;
            mem_m[waddr_m[9:0]] <= wd_last;
            wcnt <= 0;
            dcnt <= 0;
        end
    end

    // ---------------- transition monitor ----------------
    int t_ack, t_we_fall, t_we_rise, t_oe_fall, t_desel, t_dq_rise, t_dq_fall, t_rdv;
    int ack_cnt = 0, rdv_cnt = 0;
    logic [7:0]  rdv_data;
    logic [17:0] a_at_we;
    logic p_ack = 0, p_we = 1, p_oe = 1, p_sel = 0, p_dq = 0;

    always @(negedge clk) begin
        if (req_ack && !p_ack) t_ack = cyc;
        if (req_ack) ack_cnt++;
        if (!mem_wr_en_n && p_we) begin t_we_fall = cyc; a_at_we = mem_addr; end
        if (mem_wr_en_n && !p_we) t_we_rise = cyc;
        if (!mem_rd_en_n && p_oe) t_oe_fall = cyc;
        if (!m_sel && p_sel) t_desel = cyc;
        if (mem_dq_oe && !p_dq) t_dq_rise = cyc;
        if (!mem_dq_oe && p_dq) t_dq_fall = cyc;
        if (rsp_valid) begin t_rdv = cyc; rdv_data = rsp_rdata; rdv_cnt++; end
        p_ack = req_ack; p_we = mem_wr_en_n; p_oe = mem_rd_en_n;
        p_sel = m_sel; p_dq = mem_dq_oe;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    task automatic clr_stamps();
        t_ack = -1; t_we_fall = -1; t_we_rise = -1; t_oe_fall = -1;
        t_desel = -1; t_dq_rise = -1; t_dq_fall = -1; t_rdv = -1;
    endtask

    // Write one byte; checks phase lengths (R5, R6), address capture (R8), model (R7).
    task automatic t_write(input logic [17:0] a, input logic [7:0] d, input bit scramble);
        int v0 = viol;
        int ac0 = ack_cnt;
        clr_stamps();
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 0;
        if (scramble) begin req_addr = ~a; req_wdata = ~d; end
        repeat (E_WS + E_WP + E_WR + 4) @(negedge clk);
        chk(ack_cnt - ac0 == 1, "R2 write ack pulse count", ack_cnt - ac0, 1);
        chk(t_we_fall - t_ack == E_WS, "R5 setup cycles", t_we_fall - t_ack, E_WS);
        chk(t_we_rise - t_we_fall == E_WP, "R5 pulse cycles", t_we_rise - t_we_fall, E_WP);
        chk(t_desel - t_we_rise == E_WR, "R5 recover cycles", t_desel - t_we_rise, E_WR);
        chk(t_dq_rise == t_we_fall && t_dq_fall - t_we_rise == 1, "R6 drive window",
            t_dq_fall - t_we_rise, 1);
        chk(a_at_we == a, "R8 address at write", int'(a_at_we), int'(a));
        chk(viol == v0, "R7 model timing during write", viol - v0, 0);
    endtask

    // Read one byte; checks enable timing (R3) and data/strobe (R4).
    task automatic t_read(input logic [17:0] a, input logic [7:0] exp_d);
        int r0 = rdv_cnt;
        int v0 = viol;
        clr_stamps();
        @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = a;
        @(negedge clk);
        req_valid = 0;
        repeat (E_RDW + 4) @(negedge clk);
        chk(t_oe_fall - t_ack == 1, "R3 output enable delay", t_oe_fall - t_ack, 1);
        chk(t_rdv - t_ack == E_RDW + 1, "R4 read latency", t_rdv - t_ack, E_RDW + 1);
        chk(rdv_cnt - r0 == 1, "R4 single strobe", rdv_cnt - r0, 1);
        chk(rdv_data == exp_d, "R4 read data", int'(rdv_data), int'(exp_d));
        chk(viol == v0, "R7 model timing during read", viol - v0, 0);
    endtask

    // Request held high across operations: re-acknowledged only from IDLE (R2).
    task automatic t_held_request();
        int first = -1, second = -1;
        @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = 18'h00010;
        for (int i = 0; i < E_RDW + 8; i++) begin
            @(negedge clk);
            if (req_ack && first < 0) first = cyc;
            else if (req_ack && second < 0) second = cyc;
        end
        req_valid = 0;
        repeat (E_RDW + 4) @(negedge clk);
        chk(second - first == E_RDW + 3, "R2 held request spacing", second - first, E_RDW + 3);
    endtask

    // Retention entry, ignored requests, wake recovery (R9, R10).
    task automatic t_retain();
        int bad = 0, ac0, w, got = -1;
        @(negedge clk);
        retain_req = 1; req_valid = 1; req_write = 0; req_addr = 18'h00123;
        ac0 = ack_cnt;
        repeat (10) begin
            @(negedge clk);
            if (m_sel) bad++;
        end
        retain_req = 0;
        repeat (10) begin
            @(negedge clk);
            if (m_sel) bad++;
        end
        chk(ack_cnt == ac0, "R9 no ack in retention", ack_cnt - ac0, 0);
        chk(bad == 0, "R9 deselected in retention", bad, 0);
        wake_req = 1;
        @(negedge clk);
        w = cyc;
        wake_req = 0;
        bad = 0;
        for (int i = 0; i < 40 && got < 0; i++) begin
            if (req_ack) got = cyc;
            else if (m_sel) bad++;
            if (got < 0) @(negedge clk);
        end
        req_valid = 0;
        chk(got - w == E_RC + 1, "R10 wake recovery", got - w, E_RC + 1);
        chk(bad == 0, "R10 deselected during recovery", bad, 0);
        repeat (E_RDW + 4) @(negedge clk);
        chk(rdv_data == 8'h77, "R10 data kept across retention", int'(rdv_data), 8'h77);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(mem_sel_n_lo && !mem_sel_hi && mem_rd_en_n && mem_wr_en_n && !mem_dq_oe
            && !req_ack && !rsp_valid, "R1 reset outputs", 0, 1);
        rst_n = 1;
        repeat (2) @(negedge clk);
        chk(!m_sel && !req_ack, "R1 idle after reset", int'(m_sel), 0);

        t_write(18'h00005, 8'h3C, 0);
        t_read (18'h00005, 8'h3C);
        t_write(18'h00000, 8'hFF, 0);
        t_write(18'h3FFFF, 8'h00, 0);
        t_read (18'h00000, 8'hFF);
        t_read (18'h3FFFF, 8'h00);
        t_write(18'h2A1C2, 8'h96, 1);   // R8: inputs change after acceptance
        t_read (18'h2A1C2, 8'h96);
        t_write(18'h00010, 8'h5E, 0);
        t_held_request();
        t_write(18'h00123, 8'h77, 0);
        t_retain();

        chk(viol == 0, "R7 model violations total", viol, 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(200000 * PER);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule